// File: doc/BRIEF.md
# Ultra DMA Control and Status Unit

This unit sits between a processor register bus and an Ultra DMA transfer engine on a parallel disk interface. Software uses it to drive the bus select and strobe lines by hand during programmed transfers, to pick the transfer type, mode number and write hold count, and to arm the DMA engine with a direction. Turning the engine on is guarded. First a direction is written with the enable bit clear. Then the operation register is read back. Only after that may a write with the enable bit set, carrying the same direction, take effect.

The engine's request, busy, completion and error signals come in as plain inputs. The unit keeps the error flags until software clears the operation register. It folds those flags, the device interrupt line and the activity flags into a two-bit condition code with a fixed priority. A stop input performs the return to programmed I/O in one cycle. It turns the engine off, drives the selects and strobes back to their idle high level, and reloads the configuration with the last programmed-I/O mode and hold count.

Registers sit at word addresses 0 (control), 1 (configuration), 2 (operation) and 3 (status, read-only). Reads return data one cycle after the request, together with a valid pulse.

Top module: `udma_ctrl_unit`

## Requirements
- R1: After reset the control register reads 0x63: chip selects at bits 0 and 1 and the read and write strobes at bits 5 and 6 are high, and the address field in bits 4:2 is zero. The configuration, operation and status registers read zero, the engine enable is low and the condition code is 0.
- R2: The configuration register holds enable (bit 0), programmed-I/O select (bit 1), multiword-DMA select (bit 2), Ultra-DMA select (bit 3), mode (bits 7:4) and hold count (bits 9:8). It reads back what was written and drives `cfg_enable`, `cfg_xfer_sel` = {bit3, bit2, bit1}, `cfg_mode` and `cfg_hold`. A write with bit 1 set also saves the mode and hold count for later restore.
- R3: A control register write drives bits 0, 1, 4:2, 5 and 6 onto `cs0_n`, `cs1_n`, `da`, `rd_strobe_n` and `wr_strobe_n`. A read of that register shows the live `dev_intrq` input at bit 9.
- R4: The operation register has engine enable at bit 0 and direction at bit 1 (1 = data out to the device). The enable is accepted only in this order: a write with bit 0 clear, then a read of the operation register, then a write with bit 0 set and the same bit 1. After that write `eng_enable` and `eng_dir` follow the register.
- R5: A write with bit 0 set that breaks the order of R4 leaves the operation register unchanged and sets status bit 8. The order breaks when the read-back is missing, when the direction differs, or when an enable write has already been used.
- R6: Status bit 16 shows `eng_dreq` and bit 18 shows `eng_busy` live. Bit 17 (`eng_err_int`), bit 24 (`eng_err_ndo`), bit 25 (`eng_err_ndi`), bit 26 (`eng_err_n4x`) and bit 8 stay set once set. They clear only when the operation register is written with bits 1:0 both zero, or on a stop.
- R7: The condition code is 3 when any held error bit (17, 24, 25, 26) is set. Otherwise it is 2 when `dev_intrq` is high. Otherwise it is 1 when busy or request is high. Otherwise it is 0.
- R8: The engine enable clears by itself, with the direction kept, in the cycle after `eng_done` or any error input is high.
- R9: A `stop_req` pulse clears the operation register. It sets control bits 0, 1, 5 and 6 and keeps the address field. It loads the configuration with enable, programmed-I/O select and the saved mode and hold count.
- R10: A read returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| stop_req | input | 1 | Stop and return to programmed I/O |
| dev_intrq | input | 1 | Device interrupt line |
| eng_dreq | input | 1 | Engine DMA request |
| eng_busy | input | 1 | Engine not idle |
| eng_done | input | 1 | Engine transfer complete |
| eng_err_int | input | 1 | Engine error interrupt |
| eng_err_ndo | input | 1 | Data-out incomplete |
| eng_err_ndi | input | 1 | Data-in incomplete |
| eng_err_n4x | input | 1 | Count not a multiple of four words |
| eng_enable | output | 1 | Engine enable |
| eng_dir | output | 1 | Engine direction, 1 = out |
| cs0_n | output | 1 | Chip select 0, active low |
| cs1_n | output | 1 | Chip select 1, active low |
| da | output | 3 | Device register address |
| rd_strobe_n | output | 1 | Read strobe, active low |
| wr_strobe_n | output | 1 | Write strobe, active low |
| cfg_enable | output | 1 | Interface enable |
| cfg_xfer_sel | output | 3 | Transfer type {udma, mdma, pio} |
| cfg_mode | output | 4 | Mode number |
| cfg_hold | output | 2 | Write hold count |
| cond | output | 2 | Condition code |

## Verification
If the arming state is wrong, the fault shows at `eng_enable` in the cycle after the enable write, and the operation register reads back the wrong value. A lost or early-cleared error flag shows at once on `cond` and in the status read. A wrong saved mode only shows after a stop, in the configuration read-back and the `cfg_*` pins. The bench therefore reads back after every stimulus rather than trusting the pins alone.

// File: rtl/udma_cu_pkg.sv
package udma_cu_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int MODE_W   = 4;
    localparam int HOLD_W   = 2;
    localparam int SAVE_W   = MODE_W + HOLD_W;
    localparam int CFG_W    = 4 + SAVE_W;
    localparam int CTRL_W   = 7;
    localparam int N_ERR    = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CFG  = 2'd1;
    localparam logic [ADDR_W-1:0] A_OP   = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

    localparam int B_INTRQ = 9;
    localparam int B_SEQ   = 8;
    localparam int B_DREQ  = 16;
    localparam int B_EINT  = 17;
    localparam int B_BUSY  = 18;
    localparam int B_NDO   = 24;
    localparam int B_NDI   = 25;
    localparam int B_N4X   = 26;

    localparam logic [CTRL_W-1:0] CTRL_IDLE = 7'h63;

    typedef enum logic [1:0] {
        COND_IDLE   = 2'd0,
        COND_ACTIVE = 2'd1,
        COND_INTR   = 2'd2,
        COND_ERR    = 2'd3
    } cond_e;

    typedef enum logic [1:0] {
        ARM_NONE,
        ARM_WRITTEN,
        ARM_CHECKED
    } arm_e;
endpackage

// File: rtl/udma_seq_guard.sv
module udma_seq_guard
    import udma_cu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_wr,
    input  logic op_rd,
    input  logic wr_uen,
    input  logic wr_dir,
    input  logic force_idle,
    output logic accept,
    output logic reject
);
    typedef struct packed {
        arm_e stage;
        logic dir;
    } guard_t;

    guard_t q, d;

    always_comb begin
        d      = q;
        accept = op_wr && wr_uen && (q.stage == ARM_CHECKED) && (wr_dir == q.dir);
        reject = op_wr && wr_uen && !accept;
        if (force_idle) begin
            d.stage = ARM_NONE;
        end else if (op_wr && !wr_uen) begin
            d.stage = ARM_WRITTEN;
            d.dir   = wr_dir;
        end else if (op_wr) begin
            d.stage = ARM_NONE;
        end else if (op_rd && q.stage == ARM_WRITTEN) begin
            d.stage = ARM_CHECKED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{stage: ARM_NONE, dir: 1'b0};
        else        q <= d;
    end
endmodule

// File: rtl/udma_status_track.sv
module udma_status_track
    import udma_cu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_ERR-1:0]  err_in,
    input  logic              dreq,
    input  logic              busy,
    input  logic              intrq,
    input  logic              seq_bad,
    input  logic              clear,
    output logic [DATA_W-1:0] status,
    output logic [1:0]        cond,
    output logic              err_now
);
    typedef struct packed {
        logic [N_ERR-1:0] err;
        logic             seq;
    } held_t;

    held_t q, d;
    cond_e code;

    always_comb begin
        d     = q;
        if (clear) d = '0;
        d.err = d.err | err_in;
        d.seq = d.seq | seq_bad;

        err_now = |err_in;

        if (|q.err)           code = COND_ERR;
        else if (intrq)       code = COND_INTR;
        else if (busy || dreq) code = COND_ACTIVE;
        else                  code = COND_IDLE;
        cond = code;

        status         = '0;
        status[B_SEQ]  = q.seq;
        status[B_DREQ] = dreq;
        status[B_EINT] = q.err[0];
        status[B_BUSY] = busy;
        status[B_NDO]  = q.err[1];
        status[B_NDI]  = q.err[2];
        status[B_N4X]  = q.err[3];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/udma_ctrl_unit.sv
module udma_ctrl_unit
    import udma_cu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              stop_req,
    input  logic              dev_intrq,
    input  logic              eng_dreq,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic              eng_err_int,
    input  logic              eng_err_ndo,
    input  logic              eng_err_ndi,
    input  logic              eng_err_n4x,
    output logic              eng_enable,
    output logic              eng_dir,
    output logic              cs0_n,
    output logic              cs1_n,
    output logic [2:0]        da,
    output logic              rd_strobe_n,
    output logic              wr_strobe_n,
    output logic              cfg_enable,
    output logic [2:0]        cfg_xfer_sel,
    output logic [MODE_W-1:0] cfg_mode,
    output logic [HOLD_W-1:0] cfg_hold,
    output logic [1:0]        cond
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [CFG_W-1:0]  cfg;
        logic              uen;
        logic              rwop;
        logic [SAVE_W-1:0] saved;
        logic [DATA_W-1:0] rd_data;
        logic              rd_valid;
    } regs_t;

    regs_t q, d;

    logic              op_wr, op_rd, op_clear;
    logic              accept, reject, err_now;
    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] rd_mux;

    assign op_wr    = bus_wr && (bus_addr == A_OP);
    assign op_rd    = bus_rd && (bus_addr == A_OP);
    assign op_clear = stop_req || (op_wr && (bus_wdata[1:0] == 2'b00));

    udma_seq_guard guard_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_wr      (op_wr && !stop_req),
        .op_rd      (op_rd),
        .wr_uen     (bus_wdata[0]),
        .wr_dir     (bus_wdata[1]),
        .force_idle (stop_req),
        .accept     (accept),
        .reject     (reject)
    );

    udma_status_track status_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_in  ({eng_err_n4x, eng_err_ndi, eng_err_ndo, eng_err_int}),
        .dreq    (eng_dreq),
        .busy    (eng_busy),
        .intrq   (dev_intrq),
        .seq_bad (reject && !stop_req),
        .clear   (op_clear),
        .status  (status),
        .cond    (cond),
        .err_now (err_now)
    );

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_CTRL: begin
                rd_mux[CTRL_W-1:0] = q.ctrl;
                rd_mux[B_INTRQ]    = dev_intrq;
            end
            A_CFG:  rd_mux[CFG_W-1:0] = q.cfg;
            A_OP:   rd_mux[1:0] = {q.rwop, q.uen};
            default: rd_mux = status;
        endcase
    end

    always_comb begin
        d          = q;
        d.rd_valid = 1'b0;
        if (bus_rd) begin
            d.rd_valid = 1'b1;
            d.rd_data  = rd_mux;
        end

        if (eng_done || err_now) d.uen = 1'b0;

        if (stop_req) begin
            d.uen  = 1'b0;
            d.rwop = 1'b0;
            d.ctrl = q.ctrl | CTRL_IDLE;
            d.cfg  = {q.saved, 4'b0011};
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL: d.ctrl = bus_wdata[CTRL_W-1:0];
                A_CFG: begin
                    d.cfg = bus_wdata[CFG_W-1:0];
                    if (bus_wdata[1]) d.saved = bus_wdata[CFG_W-1:4];
                end
                A_OP: begin
                    if (!bus_wdata[0]) begin
                        d.uen  = 1'b0;
                        d.rwop = bus_wdata[1];
                    end else if (accept) begin
                        d.uen  = 1'b1;
                        d.rwop = bus_wdata[1];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.ctrl <= CTRL_IDLE;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata    = q.rd_data;
    assign bus_rvalid   = q.rd_valid;
    assign eng_enable   = q.uen;
    assign eng_dir      = q.rwop;
    assign cs0_n        = q.ctrl[0];
    assign cs1_n        = q.ctrl[1];
    assign da           = q.ctrl[4:2];
    assign rd_strobe_n  = q.ctrl[5];
    assign wr_strobe_n  = q.ctrl[6];
    assign cfg_enable   = q.cfg[0];
    assign cfg_xfer_sel = q.cfg[3:1];
    assign cfg_mode     = q.cfg[4+MODE_W-1:4];
    assign cfg_hold     = q.cfg[CFG_W-1:4+MODE_W];
endmodule

// File: rtl/udma_ctrl_checker.sv
module udma_ctrl_checker
    import udma_cu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              stop_req,
    input logic              dev_intrq,
    input logic              eng_done,
    input logic              eng_err_int,
    input logic              eng_err_ndo,
    input logic              eng_err_ndi,
    input logic              eng_err_n4x,
    input logic              eng_enable,
    input logic              cs0_n,
    input logic              cs1_n,
    input logic              rd_strobe_n,
    input logic              wr_strobe_n,
    input logic [1:0]        cond
);
    logic any_err;
    assign any_err = eng_err_int || eng_err_ndo || eng_err_ndi || eng_err_n4x;

    assert_enable_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_enable) |-> $past(bus_wr && bus_addr == A_OP && bus_wdata[0]));

    assert_error_holds_cond_R7: assert property (@(posedge clk) disable iff (!rst_n)
        any_err |=> cond == 2'd3);

    assert_intr_not_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dev_intrq |-> cond >= 2'd2);

    assert_done_clears_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !(bus_wr && bus_addr == A_OP)) |=> !eng_enable);

    assert_stop_idles_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (!eng_enable && cs0_n && cs1_n && rd_strobe_n && wr_strobe_n));
endmodule

bind udma_ctrl_unit udma_ctrl_checker chk_i (.*);

// File: tb/udma_ctrl_unit_tb.sv
module udma_ctrl_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [1:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        stop_req = 0, dev_intrq = 0, eng_dreq = 0, eng_busy = 0, eng_done = 0;
    logic        eng_err_int = 0, eng_err_ndo = 0, eng_err_ndi = 0, eng_err_n4x = 0;
    logic        eng_enable, eng_dir, cs0_n, cs1_n, rd_strobe_n, wr_strobe_n, cfg_enable;
    logic [2:0]  da, cfg_xfer_sel;
    logic [3:0]  cfg_mode;
    logic [1:0]  cfg_hold, cond;

    int checks = 0, errors = 0;
    bit done_flag = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    udma_ctrl_unit dut_i (.*);

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (bus_rvalid) begin
            if (exp_q.size() == 0) chk("R10 unexpected read", 32'd1, 32'd0);
            else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(logic [1:0] a, logic [31:0] v);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        // R1 reset state
        chk("R1 pins", {cs0_n, cs1_n, da, rd_strobe_n, wr_strobe_n, eng_enable}, {1'b1,1'b1,3'd0,1'b1,1'b1,1'b0});
        chk("R1 cond", cond, 0);
        rd(0, 32'h63, "R1 ctrl");
        rd(1, 0, "R1 cfg");
        rd(2, 0, "R1 op");
        rd(3, 0, "R1 status");

        // R2 configuration
        wr(1, 32'h143);
        chk("R2 cfg pins", {cfg_enable, cfg_xfer_sel, cfg_mode, cfg_hold}, {1'b1, 3'b001, 4'd4, 2'd1});
        rd(1, 32'h143, "R2 cfg readback");

        // R3 control register
        wr(0, 32'h12);
        chk("R3 ctrl pins", {cs0_n, cs1_n, da, rd_strobe_n, wr_strobe_n}, {1'b0,1'b1,3'd4,1'b0,1'b0});
        dev_intrq = 1;
        rd(0, 32'h212, "R3 intrq bit");
        dev_intrq = 0;

        // R4 legal enable sequence, out direction
        wr(2, 2);
        rd(2, 2, "R4 op armed");
        wr(2, 3);
        chk("R4 enable", {eng_enable, eng_dir}, 2'b11);
        rd(2, 3, "R4 op enabled");

        // R7 condition priority
        eng_busy = 1; step();
        chk("R7 busy active", cond, 1);
        eng_busy = 0; eng_dreq = 1; step();
        chk("R7 dreq active", cond, 1);
        dev_intrq = 1; step();
        chk("R7 intr over active", cond, 2);
        rd(3, 32'h0001_0000, "R6 dreq live");

        // R8 error clears enable, R6 sticky
        @(negedge clk); eng_err_ndi = 1;
        @(negedge clk); eng_err_ndi = 0;
        chk("R8 error clears enable", {eng_enable, eng_dir}, 2'b01);
        chk("R7 error over intr", cond, 3);
        rd(3, 32'h0201_0000, "R6 ndi sticky");
        rd(2, 2, "R8 direction kept");
        eng_dreq = 0; dev_intrq = 0; step();
        chk("R6 error held", cond, 3);
        wr(2, 0);
        chk("R6 cleared cond", cond, 0);
        rd(3, 0, "R6 cleared status");

        // R5 illegal enables
        wr(2, 1);
        chk("R5 skip readback", eng_enable, 0);
        rd(2, 0, "R5 op unchanged");
        rd(3, 32'h100, "R5 seq flag");
        wr(2, 2);
        rd(2, 2, "R5 armed");
        wr(2, 1);
        chk("R5 wrong dir", eng_enable, 0);
        rd(2, 2, "R5 op unchanged dir");
        wr(2, 3);
        chk("R5 reused arm", eng_enable, 0);
        rd(3, 32'h100, "R5 seq flag held");
        wr(2, 0);
        rd(3, 0, "R5 seq flag cleared");

        // R8 done clears enable, in direction
        rd(2, 0, "R4 armed in");
        wr(2, 1);
        chk("R4 enable in", {eng_enable, eng_dir}, 2'b10);
        @(negedge clk); eng_done = 1;
        @(negedge clk); eng_done = 0;
        chk("R8 done clears", eng_enable, 0);
        rd(2, 0, "R8 op after done");

        // R9 stop sequence
        wr(1, 32'h29);
        chk("R2 udma select", {cfg_xfer_sel, cfg_mode}, {3'b100, 4'd2});
        wr(0, 32'h08);
        wr(2, 2); rd(2, 2, "R4 rearm"); wr(2, 3);
        chk("R4 re-enable", eng_enable, 1);
        @(negedge clk); eng_err_n4x = 1; eng_err_int = 1;
        @(negedge clk); eng_err_n4x = 0; eng_err_int = 0;
        rd(3, 32'h0402_0000, "R6 n4x and int sticky");
        @(negedge clk); stop_req = 1;
        @(negedge clk); stop_req = 0;
        chk("R9 pins", {eng_enable, cs0_n, cs1_n, da, rd_strobe_n, wr_strobe_n}, {1'b0,1'b1,1'b1,3'd2,1'b1,1'b1});
        chk("R9 cfg pins", {cfg_enable, cfg_xfer_sel, cfg_mode, cfg_hold}, {1'b1, 3'b001, 4'd4, 2'd1});
        rd(0, 32'h6B, "R9 ctrl");
        rd(1, 32'h143, "R9 cfg restored");
        rd(2, 0, "R9 op cleared");
        rd(3, 0, "R9 status cleared");

        repeat (3) step();
        chk("R10 all reads returned", exp_q.size(), 0);
        finish_run();
    end
endmodule